// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block gates a network controller's interrupt causes onto a single request line. A cause register collects one-cycle event pulses from the datapath, and a 32-bit enable mask decides which pending causes raise the request. Software never writes the mask directly. One address turns on the bits written as 1. A second address turns off the bits written as 1. Bits written as 0 are left alone at both addresses, so independent software agents can each enable or disable their own sources without a read-modify-write race.

Two 16-bit delay timers count down from programmable start values and post a cause when they reach zero. When a control enable bit is set, writing all ones to the set address also reloads both timers. This gives a fixed latency before the next timer interrupt once every source has been re-enabled. Access is over a simple single-cycle register bus that uses word addresses. Read data is registered.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask, cause and control registers are all zero and `irq_o` is low.
- R2: A write to address 0x04 sets every implemented mask bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A write to address 0x05 clears every mask bit written as 1 and leaves the others unchanged. This is the only way a mask bit returns to 0.
- R4: A read presents its data on `rdata` one cycle after `rd_en`. Address 0x04 returns the current mask, and address 0x05 returns 0.
- R5: Only bit positions 0,1,2,4,6,7,9,15,16,17,20,22,24 (constant 0x015382D7) exist in the mask and cause registers. All other positions ignore writes and events, and they read back as 0.
- R6: A one-cycle pulse on `event_i[n]` sets cause bit n. A read of address 0x00 returns the cause and then clears it, but an event arriving in the same cycle as that read stays set.
- R7: `irq_o` is high exactly while some bit is set in both the cause and the mask.
- R8: Control bit 0 at address 0x06 enables timer reload. When it is 1, a write of 0xFFFFFFFF to address 0x04 reloads every delay timer with its start value. When it is 0, the timers are not touched.
- R9: Timer k takes its start value from the low 16 bits of address 0x08+k. After a reload it counts down by one per cycle. On the cycle it reaches zero it sets cause bit 7 (timer 0) or bit 24 (timer 1). A timer at zero stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| event_i | input | 32 | One-cycle cause pulses from the datapath |
| irq_o | output | 1 | Interrupt request |

## Verification
The mask is tried in several ways. First, a single-bit set and clear is swept over all 32 positions. This separates implemented bits from reserved ones and shows that set and clear act on only one bit. Next, a run of pseudo-random set and clear words is checked against a bench model of the mask. This exposes any write that disturbs bits written as 0. An event sweep per bit, with the mask on and with it off, shows whether the request follows the AND of cause and mask or only one of them. The timer tests compare an all-ones set write with control enabled against the same write with control disabled. They also check the exact cycle of expiry, which catches off-by-one errors in the reload and countdown.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int TMR_W   = 16;
    localparam int NUM_TMR = 2;

    localparam logic [DATA_W-1:0] IMPL_BITS = 32'h0153_82D7;

    localparam logic [ADDR_W-1:0] A_CAUSE    = 8'h00;
    localparam logic [ADDR_W-1:0] A_MSET     = 8'h04;
    localparam logic [ADDR_W-1:0] A_MCLR     = 8'h05;
    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h06;
    localparam logic [ADDR_W-1:0] A_TINIT0   = 8'h08;

    typedef enum logic [2:0] {
        OP_NONE, OP_SET, OP_CLR, OP_CTRL, OP_TINIT, OP_CAUSE
    } reg_op_e;

    typedef struct packed {
        reg_op_e           op;
        logic              is_rd;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic int tmr_cause_bit(input int k);
        return (k == 0) ? 7 : 24;
    endfunction

    function automatic reg_op_e decode(input logic [ADDR_W-1:0] a);
        if (a == A_CAUSE) return OP_CAUSE;
        if (a == A_MSET)  return OP_SET;
        if (a == A_MCLR)  return OP_CLR;
        if (a == A_CTRL)  return OP_CTRL;
        if (a >= A_TINIT0 && a < A_TINIT0 + NUM_TMR) return OP_TINIT;
        return OP_NONE;
    endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL = IMPL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);
    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (set_we)
            mask_q <= mask_q | (wdata & IMPL);
        else if (clr_we)
            mask_q <= mask_q & ~wdata;
    end

    assign mask = mask_q;

    assert_set_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((mask & $past(mask)) == $past(mask)) &&
                   ((mask & $past(wdata & IMPL)) == $past(wdata & IMPL)));

    assert_clr_drops_R3: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((mask & $past(wdata)) == '0) &&
                   ((mask | $past(wdata)) == ($past(mask) | $past(wdata))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(mask));
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
    import irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL = IMPL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] cause
);
    logic [DATA_W-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else
            cause_q <= (rd_clr ? '0 : cause_q) | (set_vec & IMPL);
    end

    assign cause = cause_q;

    assert_event_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & IMPL)) |=> ((cause & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] init_val,
    output logic             expire
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= init_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = !load && (cnt_q == TMR_W'(1));

    assert_countdown_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(init_val)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [31:0]       event_i,
    output logic              irq_o
);
    localparam int TIDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    bus_req_t          req;
    logic [DATA_W-1:0] mask, cause, tmr_vec, rd_mux, rdata_q;
    logic              ctrl_q, tmr_load;
    logic [TMR_W-1:0]  tinit_q [NUM_TMR];
    logic [NUM_TMR-1:0] tmr_exp;
    logic [TIDX_W-1:0] tidx;

    always_comb begin
        req.op    = decode(addr);
        req.is_rd = rd_en;
        req.data  = wdata;
    end

    assign tidx     = TIDX_W'(addr - A_TINIT0);
    assign tmr_load = wr_en && req.op == OP_SET && ctrl_q && (&req.data);

    irq_mask_reg u_mask (
        .clk(clk), .rst(rst),
        .set_we(wr_en && req.op == OP_SET),
        .clr_we(wr_en && req.op == OP_CLR),
        .wdata(req.data), .mask(mask)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= 1'b0;
        else if (wr_en && req.op == OP_CTRL)
            ctrl_q <= req.data[0];
    end

    always_comb begin
        tmr_vec = '0;
        for (int k = 0; k < NUM_TMR; k++)
            tmr_vec[tmr_cause_bit(k)] = tmr_exp[k];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_TMR; g++) begin : g_tmr
            always_ff @(posedge clk) begin
                if (rst)
                    tinit_q[g] <= '0;
                else if (wr_en && req.op == OP_TINIT && tidx == TIDX_W'(g))
                    tinit_q[g] <= req.data[TMR_W-1:0];
            end

            irq_delay_timer u_tmr (
                .clk(clk), .rst(rst), .load(tmr_load),
                .init_val(tinit_q[g]), .expire(tmr_exp[g])
            );
        end
    endgenerate

    irq_cause_reg u_cause (
        .clk(clk), .rst(rst),
        .set_vec(event_i | tmr_vec),
        .rd_clr(rd_en && req.op == OP_CAUSE),
        .cause(cause)
    );

    always_comb begin
        unique case (req.op)
            OP_CAUSE: rd_mux = cause;
            OP_SET:   rd_mux = mask;
            OP_CTRL:  rd_mux = {{(DATA_W-1){1'b0}}, ctrl_q};
            OP_TINIT: rd_mux = {{(DATA_W-TMR_W){1'b0}}, tinit_q[tidx]};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (req.is_rd)
            rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
    assign irq_o = |(cause & mask);

    assert_irq_persists_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !rd_en && !wr_en) |=> irq_o);

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && !wr_en && event_i == '0 && tmr_exp == '0) |=> !irq_o);
endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IMPL = 32'h0153_82D7;

    logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, irq_o;
    logic [7:0] addr = 0;
    logic [31:0] wdata = 0, rdata, event_i = 0;
    int total = 0, bad = 0;
    logic [31:0] model, got, lfsr;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_mask_ctrl i_irq_mask_ctrl (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .event_i(event_i), .irq_o(irq_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk); event_i = e;
        @(negedge clk); event_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 0);
        rd(8'h04, got); check("R1 mask", got, 0);
        rd(8'h00, got); check("R1 cause", got, 0);
        rd(8'h06, got); check("R1 ctrl", got, 0);

        // R2/R3/R5 single-bit sweep
        for (int i = 0; i < 32; i++) begin
            wr(8'h04, 32'h1 << i);
            rd(8'h04, got); check("R2 R5 set bit", got, (32'h1 << i) & IMPL);
            wr(8'h04, 32'h0);
            rd(8'h04, got); check("R2 zero write keeps", got, (32'h1 << i) & IMPL);
            wr(8'h05, 32'h1 << i);
            rd(8'h04, got); check("R3 clear bit", got, 0);
        end

        // R2/R3/R4 pseudo-random set/clear against a model
        model = 0; lfsr = 32'hACE1_1234;
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3]) begin wr(8'h04, lfsr); model = model | (lfsr & IMPL); end
            else begin wr(8'h05, lfsr); model = model & ~lfsr; end
            rd(8'h04, got); check("R2 R3 model", got, model);
        end
        rd(8'h05, got); check("R4 clear addr reads zero", got, 0);
        wr(8'h05, 32'hFFFF_FFFF);

        // R6/R7 event sweep, mask off then on
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            check("R7 masked off", {31'b0, irq_o}, 0);
            wr(8'h04, 32'h1 << i);
            check("R7 masked on", {31'b0, irq_o}, ((32'h1 << i) & IMPL) != 0);
            rd(8'h00, got); check("R6 R5 cause read", got, (32'h1 << i) & IMPL);
            check("R7 cleared", {31'b0, irq_o}, 0);
            rd(8'h00, got); check("R6 cleared by read", got, 0);
            wr(8'h05, 32'h1 << i);
        end

        // R6 event in the same cycle as the clearing read
        @(negedge clk); rd_en = 1; addr = 8'h00; event_i = 32'h4;
        @(negedge clk); rd_en = 0; event_i = 0;
        check("R6 same-cycle read data", rdata, 0);
        rd(8'h00, got); check("R6 same-cycle event kept", got, 32'h4);

        // R8/R9 timer reload enabled
        wr(8'h08, 32'h0001_0005);
        rd(8'h08, got); check("R9 init readback", got, 32'h5);
        wr(8'h06, 32'h1);
        rd(8'h00, got);
        @(negedge clk); wr_en = 1; addr = 8'h04; wdata = 32'hFFFF_FFFF;
        @(negedge clk); wr_en = 0;
        repeat (4) @(negedge clk);
        check("R9 not yet expired", {31'b0, irq_o}, 0);
        @(negedge clk);
        check("R9 expiry cycle", {31'b0, irq_o}, 1);
        rd(8'h00, got); check("R9 timer0 cause bit", got, 32'h80);
        repeat (10) @(negedge clk);
        check("R9 idle after zero", {31'b0, irq_o}, 0);

        // R8 reload disabled
        wr(8'h06, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);
        repeat (12) @(negedge clk);
        check("R8 no reload when disabled", {31'b0, irq_o}, 0);
        rd(8'h00, got); check("R8 cause stays clear", got, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule